// File: doc/BRIEF.md
# Stack Frame Push/Pop Unit

This unit carries out the frame bookkeeping of procedure entry and exit as single operations. A push lowers the stack pointer by one 8-byte slot. It writes the link register and frame pointer into that slot as one 64-bit word, moves the frame pointer to the slot and then reserves a local area below it. A pop reads the 64-bit pair back from a given frame address. It hands the link register and frame pointer back as new register values and moves the stack pointer just above the slot. The pop-and-jump variant also redirects the program counter to the restored link value. The guarded form of that variant runs only when a predicate bit matches a required sense.

The unit takes one operation at a time from a single-cycle offer. It talks to memory over a simple 64-bit request/acknowledge handshake. Register updates come back as write strobes with values, which the surrounding pipeline commits. An operation that would touch memory at an address that is not 8-byte aligned is refused with an error pulse instead of a memory access.

Top module: `frame_unit`

## Requirements
- R1: A push (opKind 2'b00) requests a memory write (memWe=1) at address spIn-8, with memWdata holding lrIn in bits 63:32 and fpIn in bits 31:0.
- R2: On completion of a push, fpWr and spWr pulse, with fpOut equal to the slot address and spOut equal to the slot address minus frameSize*8 (frameSize unsigned, 11 bits). lrWr stays low.
- R3: A pop (opKind 2'b01, 2'b10 or 2'b11) requests a memory read (memWe=0) at frameAddrIn. On completion, spWr pulses with spOut equal to frameAddrIn+8.
- R4: On completion of a pop, lrWr and fpWr pulse, with lrOut equal to memRdata bits 63:32 and fpOut equal to memRdata bits 31:0, as captured in the acknowledge cycle.
- R5: Pop-and-jump (2'b10, and 2'b11 when it runs) pulses jumpValid together with the restore, with jumpTarget equal to memRdata bits 63:32. Push and plain pop (2'b01) never raise jumpValid.
- R6: Guarded pop-and-jump (2'b11) runs only when predBit equals predSense. Otherwise no memory request is made, done pulses one cycle after the offer, and no write strobe, jump or error is raised, whatever the address.
- R7: busy and memReq are high from the cycle after acceptance through the acknowledge cycle. memAddr and memWdata hold steady until memAck. An offer made while busy is ignored. An offer made in the cycle after the acknowledge is accepted.
- R8: If an operation that would run has an address whose bits 2:0 are not zero, misalignErr pulses one cycle after the offer, and no request, done or write strobe follows.
- R9: During and right after reset, busy, memReq, done, misalignErr, all write strobes and jumpValid are low.
- R10: Results and done appear in the cycle after the acknowledge cycle, and done lasts one cycle unless another operation completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | Operation offer, taken when not busy |
| opKind | input | 2 | 00 push, 01 pop, 10 pop-and-jump, 11 guarded pop-and-jump |
| spIn | input | 32 | Current stack pointer |
| fpIn | input | 32 | Current frame pointer |
| lrIn | input | 32 | Current link register |
| frameSize | input | 11 | Local area size in 8-byte units (push) |
| frameAddrIn | input | 32 | Frame address to pop from |
| predBit | input | 1 | Predicate bit for guarded pop |
| predSense | input | 1 | Required predicate value |
| busy | output | 1 | Operation waiting on memory |
| misalignErr | output | 1 | Refused misaligned operation pulse |
| memReq | output | 1 | Memory request |
| memWe | output | 1 | Request is a write |
| memAddr | output | 32 | Request address |
| memWdata | output | 64 | Write data |
| memAck | input | 1 | Memory acknowledge |
| memRdata | input | 64 | Read data, valid with memAck |
| done | output | 1 | Operation finished pulse |
| spWr | output | 1 | Stack pointer update strobe |
| spOut | output | 32 | New stack pointer |
| fpWr | output | 1 | Frame pointer update strobe |
| fpOut | output | 32 | New frame pointer |
| lrWr | output | 1 | Link register update strobe |
| lrOut | output | 32 | New link register |
| jumpValid | output | 1 | Program counter redirect strobe |
| jumpTarget | output | 32 | Redirect target |

## Verification
The memory acknowledge that finishes one operation and a fresh offer can arrive in the same cycle. The offer must then be dropped, while an offer in the following cycle must start a new request. The bench holds a pop offer high through the whole wait of a push, including the acknowledge cycle. It then confirms that the push address and data stayed put, that the push results appear unchanged, and that exactly one pop request begins right after, at the pop's address. Guarded pops with both predicate senses, misaligned addresses, and a guarded pop that is skipped despite a misaligned address check that skipping and refusing never overlap.

// File: rtl/frame_pkg.sv
package frame_pkg;
  typedef enum logic [1:0] {
    OP_PUSH     = 2'b00,
    OP_POP      = 2'b01,
    OP_POPJMP   = 2'b10,
    OP_POPJMPIF = 2'b11
  } frameOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic take;      // start a memory access
    logic finish;    // memory acknowledged
    logic misalign;  // refuse: bad alignment
    logic skip;      // guarded op not run
  } ctrlStb_t;
endpackage

// File: rtl/frame_ctrl.sv
module frame_ctrl (
  input  logic                clk,
  input  logic                rstN,
  input  logic                opValid,
  input  frame_pkg::frameOp_e opKind,
  input  logic                predBit,
  input  logic                predSense,
  input  logic                addrMisaligned,
  input  logic                memAck,
  output frame_pkg::ctrlStb_t stb,
  output logic                busy,
  output logic                memReq
);
  import frame_pkg::*;

  logic waiting;
  logic offerSeen;
  logic runs;

  always_comb begin
    offerSeen    = opValid && !waiting;
    runs         = (opKind != OP_POPJMPIF) || (predBit == predSense);
    stb.take     = offerSeen && runs && !addrMisaligned;
    stb.misalign = offerSeen && runs && addrMisaligned;
    stb.skip     = offerSeen && !runs;
    stb.finish   = waiting && memAck;
  end

  always_ff @(posedge clk) begin
    if (!rstN)           waiting <= 1'b0;
    else if (stb.take)   waiting <= 1'b1;
    else if (stb.finish) waiting <= 1'b0;
  end

  assign busy   = waiting;
  assign memReq = waiting;

  // R7
  wait_until_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    waiting && !memAck |=> waiting);

  // R6
  skip_no_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.skip |=> !waiting);
endmodule

// File: rtl/frame_dp.sv
module frame_dp #(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 11
) (
  input  logic                clk,
  input  logic                rstN,
  input  frame_pkg::ctrlStb_t stb,
  input  frame_pkg::frameOp_e opKind,
  input  logic [ADDR_W-1:0]   spIn,
  input  logic [ADDR_W-1:0]   fpIn,
  input  logic [ADDR_W-1:0]   lrIn,
  input  logic [SIZE_W-1:0]   frameSize,
  input  logic [ADDR_W-1:0]   frameAddrIn,
  input  logic [2*ADDR_W-1:0] memRdata,
  output logic                addrMisaligned,
  output logic [ADDR_W-1:0]   memAddr,
  output logic                memWe,
  output logic [2*ADDR_W-1:0] memWdata,
  output logic                done,
  output logic                misalignErr,
  output logic                spWr,
  output logic [ADDR_W-1:0]   spOut,
  output logic                fpWr,
  output logic [ADDR_W-1:0]   fpOut,
  output logic                lrWr,
  output logic [ADDR_W-1:0]   lrOut,
  output logic                jumpValid,
  output logic [ADDR_W-1:0]   jumpTarget
);
  import frame_pkg::*;

  localparam int SLOT_B  = ADDR_W / 4;
  localparam int ALIGN_W = $clog2(SLOT_B);
  localparam int DATA_W  = 2 * ADDR_W;

  logic [ADDR_W-1:0] eaNow, spAfterPush;
  logic [ADDR_W-1:0] eaReg, spPushReg;
  logic [DATA_W-1:0] wdataReg;
  frameOp_e          kindReg;

  always_comb begin
    eaNow          = (opKind == OP_PUSH) ? spIn - ADDR_W'(SLOT_B) : frameAddrIn;
    spAfterPush    = eaNow - (ADDR_W'(frameSize) << ALIGN_W);
    addrMisaligned = |eaNow[ALIGN_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      eaReg     <= '0;
      spPushReg <= '0;
      wdataReg  <= '0;
      kindReg   <= OP_PUSH;
    end else if (stb.take) begin
      eaReg     <= eaNow;
      spPushReg <= spAfterPush;
      wdataReg  <= {lrIn, fpIn};
      kindReg   <= opKind;
    end
  end

  assign memAddr  = eaReg;
  assign memWdata = wdataReg;
  assign memWe    = (kindReg == OP_PUSH);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      done        <= 1'b0;
      misalignErr <= 1'b0;
      spWr        <= 1'b0;
      fpWr        <= 1'b0;
      lrWr        <= 1'b0;
      jumpValid   <= 1'b0;
      spOut       <= '0;
      fpOut       <= '0;
      lrOut       <= '0;
      jumpTarget  <= '0;
    end else begin
      done        <= stb.skip || stb.finish;
      misalignErr <= stb.misalign;
      spWr        <= 1'b0;
      fpWr        <= 1'b0;
      lrWr        <= 1'b0;
      jumpValid   <= 1'b0;
      if (stb.finish) begin
        spWr <= 1'b1;
        fpWr <= 1'b1;
        if (kindReg == OP_PUSH) begin
          spOut <= spPushReg;
          fpOut <= eaReg;
        end else begin
          lrWr       <= 1'b1;
          spOut      <= eaReg + ADDR_W'(SLOT_B);
          lrOut      <= memRdata[DATA_W-1:ADDR_W];
          fpOut      <= memRdata[ADDR_W-1:0];
          jumpValid  <= (kindReg == OP_POPJMP) || (kindReg == OP_POPJMPIF);
          jumpTarget <= memRdata[DATA_W-1:ADDR_W];
        end
      end
    end
  end

  // R5
  jump_with_restore_chk: assert property (@(posedge clk) disable iff (!rstN)
    jumpValid |-> lrWr && done);

  // R8
  err_excl_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    misalignErr |-> !done && !spWr);
endmodule

// File: rtl/frame_unit.sv
module frame_unit #(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 11
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                opValid,
  input  logic [1:0]          opKind,
  input  logic [ADDR_W-1:0]   spIn,
  input  logic [ADDR_W-1:0]   fpIn,
  input  logic [ADDR_W-1:0]   lrIn,
  input  logic [SIZE_W-1:0]   frameSize,
  input  logic [ADDR_W-1:0]   frameAddrIn,
  input  logic                predBit,
  input  logic                predSense,
  output logic                busy,
  output logic                misalignErr,
  output logic                memReq,
  output logic                memWe,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [2*ADDR_W-1:0] memWdata,
  input  logic                memAck,
  input  logic [2*ADDR_W-1:0] memRdata,
  output logic                done,
  output logic                spWr,
  output logic [ADDR_W-1:0]   spOut,
  output logic                fpWr,
  output logic [ADDR_W-1:0]   fpOut,
  output logic                lrWr,
  output logic [ADDR_W-1:0]   lrOut,
  output logic                jumpValid,
  output logic [ADDR_W-1:0]   jumpTarget
);
  import frame_pkg::*;

  localparam int SLOT_B  = ADDR_W / 4;
  localparam int ALIGN_W = $clog2(SLOT_B);

  frameOp_e kindE;
  ctrlStb_t stb;
  logic     addrMisaligned;

  assign kindE = frameOp_e'(opKind);

  frame_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opKind(kindE),
    .predBit(predBit), .predSense(predSense), .addrMisaligned(addrMisaligned),
    .memAck(memAck), .stb(stb), .busy(busy), .memReq(memReq)
  );

  frame_dp #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .opKind(kindE),
    .spIn(spIn), .fpIn(fpIn), .lrIn(lrIn), .frameSize(frameSize),
    .frameAddrIn(frameAddrIn), .memRdata(memRdata),
    .addrMisaligned(addrMisaligned), .memAddr(memAddr), .memWe(memWe),
    .memWdata(memWdata), .done(done), .misalignErr(misalignErr),
    .spWr(spWr), .spOut(spOut), .fpWr(fpWr), .fpOut(fpOut),
    .lrWr(lrWr), .lrOut(lrOut), .jumpValid(jumpValid), .jumpTarget(jumpTarget)
  );

  // R1
  req_aligned_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> memAddr[ALIGN_W-1:0] == '0);

  // R7
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq && $stable(memAddr) && $stable(memWdata));

  // R10
  ack_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memAck |=> done);

  // R2
  push_fp_chk: assert property (@(posedge clk) disable iff (!rstN)
    done && fpWr && !lrWr |-> fpOut == $past(memAddr));

  // R3
  pop_sp_chk: assert property (@(posedge clk) disable iff (!rstN)
    done && lrWr |-> spOut == $past(memAddr) + ADDR_W'(SLOT_B));

  // R8
  err_no_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    misalignErr |-> !memReq);
endmodule

// File: tb/tb_frame_unit.sv
module tb_frame_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic [1:0]  opKind = '0;
  logic [31:0] spIn = '0, fpIn = '0, lrIn = '0, frameAddrIn = '0;
  logic [10:0] frameSize = '0;
  logic        predBit = 1'b0, predSense = 1'b0;
  logic        memAck = 1'b0;
  logic [63:0] memRdata = '0;
  logic        busy, misalignErr, memReq, memWe, done, spWr, fpWr, lrWr, jumpValid;
  logic [31:0] memAddr, spOut, fpOut, lrOut, jumpTarget;
  logic [63:0] memWdata;

  int nChk = 0;
  int nBad = 0;

  always #2 clk = ~clk;

  frame_unit dut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opKind(opKind),
    .spIn(spIn), .fpIn(fpIn), .lrIn(lrIn), .frameSize(frameSize),
    .frameAddrIn(frameAddrIn), .predBit(predBit), .predSense(predSense),
    .busy(busy), .misalignErr(misalignErr), .memReq(memReq), .memWe(memWe),
    .memAddr(memAddr), .memWdata(memWdata), .memAck(memAck), .memRdata(memRdata),
    .done(done), .spWr(spWr), .spOut(spOut), .fpWr(fpWr), .fpOut(fpOut),
    .lrWr(lrWr), .lrOut(lrOut), .jumpValid(jumpValid), .jumpTarget(jumpTarget)
  );

  typedef struct packed {
    logic [1:0]  kind;
    logic [31:0] sp;
    logic [31:0] fp;
    logic [31:0] lr;
    logic [10:0] size;
    logic [31:0] fa;
    logic        pb;
    logic        ps;
    logic [63:0] rd;
    logic [3:0]  lat;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 32'h0000_1000, 32'h0000_2000, 32'h3000_0040, 11'd4,    32'h0, 1'b0, 1'b0, 64'h0, 4'd0},
    '{2'd0, 32'h0001_0000, 32'h0000_1234, 32'h8765_4320, 11'd2047, 32'h0, 1'b0, 1'b0, 64'h0, 4'd2},
    '{2'd1, 32'h0,         32'h0,         32'h0,         11'd0,    32'h0000_0800, 1'b0, 1'b0, 64'h1111_2222_3333_4440, 4'd1},
    '{2'd2, 32'h0,         32'h0,         32'h0,         11'd0,    32'h0000_0FF0, 1'b0, 1'b0, 64'h0000_4000_0000_0E00, 4'd3},
    '{2'd3, 32'h0,         32'h0,         32'h0,         11'd0,    32'h0000_0A00, 1'b1, 1'b1, 64'hCAFE_0010_0000_0A08, 4'd0},
    '{2'd3, 32'h0,         32'h0,         32'h0,         11'd0,    32'h0000_0A00, 1'b0, 1'b1, 64'hDEAD_BEEF_0000_0000, 4'd0},
    '{2'd3, 32'h0,         32'h0,         32'h0,         11'd0,    32'h0000_0B00, 1'b0, 1'b0, 64'h0000_5550_0000_0B40, 4'd1},
    '{2'd0, 32'h0000_1004, 32'h0,         32'h0,         11'd1,    32'h0, 1'b0, 1'b0, 64'h0, 4'd0},
    '{2'd1, 32'h0,         32'h0,         32'h0,         11'd0,    32'h0000_080C, 1'b0, 1'b0, 64'h0, 4'd0},
    '{2'd3, 32'h0,         32'h0,         32'h0,         11'd0,    32'h0000_0C03, 1'b1, 1'b0, 64'h0, 4'd0},
    '{2'd0, 32'h0000_0008, 32'h0000_0100, 32'h0000_0200, 11'd1,    32'h0, 1'b0, 1'b0, 64'h0, 4'd0}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic runOp(input vec_t v);
    logic [31:0] ea;
    bit runsOp, isErr;
    ea     = (v.kind == 2'd0) ? v.sp - 32'd8 : v.fa;
    runsOp = (v.kind != 2'd3) || (v.pb == v.ps);
    isErr  = runsOp && (ea[2:0] != 3'd0);
    @(negedge clk);
    opKind = v.kind; spIn = v.sp; fpIn = v.fp; lrIn = v.lr;
    frameSize = v.size; frameAddrIn = v.fa; predBit = v.pb; predSense = v.ps;
    opValid = 1'b1;
    @(negedge clk);
    opValid = 1'b0;
    if (!runsOp) begin
      // R6: skipped guarded pop
      chk(done && !spWr && !fpWr && !lrWr && !jumpValid && !memReq && !misalignErr,
          "R6", "skip flags", {57'd0, done, spWr, fpWr, lrWr, jumpValid, memReq, misalignErr},
          64'h40);
    end else if (isErr) begin
      // R8: misaligned refusal
      chk(misalignErr && !memReq && !busy && !done, "R8", "refuse flags",
          {60'd0, misalignErr, memReq, busy, done}, 64'h8);
      @(negedge clk);
      chk(!done && !spWr && !memReq && !misalignErr, "R8", "no follow-up",
          {60'd0, done, spWr, memReq, misalignErr}, 64'h0);
    end else begin
      chk(memReq && busy, "R7", "req busy", {62'd0, memReq, busy}, 64'h3);
      chk(memAddr == ea, (v.kind == 2'd0) ? "R1" : "R3", "memAddr", {32'd0, memAddr}, {32'd0, ea});
      chk(memWe == (v.kind == 2'd0), (v.kind == 2'd0) ? "R1" : "R3", "memWe",
          {63'd0, memWe}, {63'd0, (v.kind == 2'd0)});
      if (v.kind == 2'd0)
        chk(memWdata == {v.lr, v.fp}, "R1", "memWdata", memWdata, {v.lr, v.fp});
      for (int i = 0; i < int'(v.lat); i++) begin
        @(negedge clk);
        chk(memReq && busy && memAddr == ea, "R7", "hold while waiting", {32'd0, memAddr}, {32'd0, ea});
      end
      memAck = 1'b1; memRdata = v.rd;
      @(negedge clk);
      memAck = 1'b0;
      chk(done && !busy && !memReq, "R10", "done after ack", {61'd0, done, busy, memReq}, 64'h4);
      if (v.kind == 2'd0) begin
        chk(spWr && fpWr && !lrWr, "R2", "push strobes", {61'd0, spWr, fpWr, lrWr}, 64'h6);
        chk(fpOut == ea, "R2", "fpOut", {32'd0, fpOut}, {32'd0, ea});
        chk(spOut == ea - ({21'd0, v.size} << 3), "R2", "spOut", {32'd0, spOut},
            {32'd0, ea - ({21'd0, v.size} << 3)});
        chk(!jumpValid, "R5", "no jump on push", {63'd0, jumpValid}, 64'h0);
      end else begin
        chk(spWr && fpWr && lrWr, "R4", "pop strobes", {61'd0, spWr, fpWr, lrWr}, 64'h7);
        chk(lrOut == v.rd[63:32], "R4", "lrOut", {32'd0, lrOut}, {32'd0, v.rd[63:32]});
        chk(fpOut == v.rd[31:0], "R4", "fpOut", {32'd0, fpOut}, {32'd0, v.rd[31:0]});
        chk(spOut == ea + 32'd8, "R3", "spOut", {32'd0, spOut}, {32'd0, ea + 32'd8});
        chk(jumpValid == (v.kind != 2'd1), "R5", "jumpValid", {63'd0, jumpValid},
            {63'd0, (v.kind != 2'd1)});
        if (v.kind != 2'd1)
          chk(jumpTarget == v.rd[63:32], "R5", "jumpTarget", {32'd0, jumpTarget}, {32'd0, v.rd[63:32]});
      end
    end
    @(negedge clk);
    chk(!done && !spWr && !jumpValid && !misalignErr, "R10", "single pulse",
        {60'd0, done, spWr, jumpValid, misalignErr}, 64'h0);
  endtask

  initial begin
    #(4ns * 100000);
    nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    chk(!busy && !memReq && !done && !misalignErr && !spWr && !fpWr && !lrWr && !jumpValid,
        "R9", "in reset", {56'd0, busy, memReq, done, misalignErr, spWr, fpWr, lrWr, jumpValid}, 64'h0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!busy && !memReq && !done && !misalignErr && !spWr && !fpWr && !lrWr && !jumpValid,
        "R9", "after reset", {56'd0, busy, memReq, done, misalignErr, spWr, fpWr, lrWr, jumpValid}, 64'h0);

    for (int k = 0; k < NV; k++) runOp(VEC[k]);

    // R7: offer held during a push wait and ack cycle is ignored, then taken
    @(negedge clk);
    opKind = 2'd0; spIn = 32'h0000_2000; fpIn = 32'h0000_AAA8; lrIn = 32'h0000_BBB0;
    frameSize = 11'd3; opValid = 1'b1;
    @(negedge clk);
    opKind = 2'd1; frameAddrIn = 32'h0000_0100;
    repeat (2) begin
      @(negedge clk);
      chk(memReq && memWe && memAddr == 32'h0000_1FF8 && memWdata == 64'h0000_BBB0_0000_AAA8,
          "R7", "push held under offer", {32'd0, memAddr}, 64'h1FF8);
    end
    memAck = 1'b1;
    @(negedge clk);
    memAck = 1'b0;
    chk(done && fpOut == 32'h0000_1FF8 && spOut == 32'h0000_1FE0 && !lrWr,
        "R7", "push result intact", {fpOut, spOut}, 64'h0000_1FF8_0000_1FE0);
    @(negedge clk);
    opValid = 1'b0;
    chk(memReq && !memWe && memAddr == 32'h0000_0100, "R7", "offer taken after ack",
        {31'd0, memWe, memAddr}, 64'h100);
    memAck = 1'b1; memRdata = 64'h0000_0777_0000_0888;
    @(negedge clk);
    memAck = 1'b0;
    chk(done && lrOut == 32'h0000_0777 && spOut == 32'h0000_0108, "R4", "second op result",
        {lrOut, spOut}, 64'h0000_0777_0000_0108);
    @(negedge clk);
    chk(!memReq && !busy && !done, "R7", "only one extra op", {61'd0, memReq, busy, done}, 64'h0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule